// File: doc/BRIEF.md
# Two-Step Jump Program Counter

This block produces the 8-bit instruction address for a small processor whose jump operand arrives four bits at a time. The operand bus is only a nibble wide, so a full 8-bit jump target is built in two steps. First, an active-low strobe captures the bus value into a holding register for the upper address nibble. Later, a jump load writes the bus value as the low nibble, and the held upper nibble as the high nibble, into the counter in a single edge.

When no reset or load is active, the counter advances by one on every rising clock edge and wraps from 0xFF back to 0x00. The holding register and the counter each have their own synchronous active-high clear, so either one can be cleared without disturbing the other. Instruction decoding, clock generation and the instruction memory are outside this block.

Top module: `nibble_jump_pc`

## Requirements
- R1: When `pc_clr` is high at a rising edge, `addr` is 0x00 after that edge.
- R2: When `pc_clr` and `jump_ld` are both low at a rising edge, `addr` becomes the previous `addr` plus one.
- R3: Counting from 0xFF gives 0x00 on the next edge.
- R4: When `hi_stb_n` is low at a rising edge, the bus value becomes the held upper nibble. A later jump shows it in `addr[7:4]`.
- R5: While `hi_stb_n` stays high, the held upper nibble keeps its value, whatever the bus carries.
- R6: When `jump_ld` is high and `pc_clr` is low at a rising edge, `addr` becomes {held upper nibble, `opnd`} after that edge.
- R7: When `hi_clr` is high at a rising edge, the held upper nibble becomes 0x0. The counter keeps counting through that edge.
- R8: `pc_clr` takes priority over `jump_ld`. If both are high at an edge, `addr` is 0x00.
- R9: If `hi_stb_n` is low and `jump_ld` is high at the same edge, the jump uses the upper nibble held before that edge. The newly strobed nibble applies to later jumps.
- R10: If `hi_clr` is high and `hi_stb_n` is low at the same edge, the held nibble becomes 0x0.
- R11: `pc_clr` leaves the held upper nibble unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| hi_clr | input | 1 | Synchronous active-high clear of the held upper nibble |
| pc_clr | input | 1 | Synchronous active-high clear of the counter |
| opnd | input | 4 | Shared operand nibble bus |
| hi_stb_n | input | 1 | Active-low strobe that captures `opnd` as the upper nibble |
| jump_ld | input | 1 | Loads {held nibble, `opnd`} into the counter |
| addr | output | 8 | Instruction address |

## Verification
The assertions assume that both clears are held high for at least one edge before any other activity. This gives the held nibble and the counter known values before they are compared against their past values. The stimulus starts with both clears high and changes inputs only on falling edges, so every input is stable around each rising edge. Jumps are checked only after the held nibble has been strobed or cleared, which keeps every expected target fully determined.

// File: rtl/njpc_pkg.sv
package njpc_pkg;
    localparam int ADDR_W = 8;
    localparam int NIB_W  = 4;
    localparam int HI_W   = ADDR_W - NIB_W;

    typedef enum logic [1:0] {
        PC_CLEAR = 2'd0,
        PC_JUMP  = 2'd1,
        PC_STEP  = 2'd2
    } pc_op_e;

    typedef struct packed {
        logic clr;
        logic ld;
    } pc_ctl_t;

    // Priority: clear, then jump, then step.
    function automatic pc_op_e pick_op(pc_ctl_t c);
        if (c.clr)     return PC_CLEAR;
        else if (c.ld) return PC_JUMP;
        else           return PC_STEP;
    endfunction

    function automatic logic [ADDR_W-1:0] join_target(
        logic [HI_W-1:0] hi, logic [NIB_W-1:0] lo);
        return {hi, lo};
    endfunction
endpackage

// File: rtl/njpc_hi_hold.sv
module njpc_hi_hold
    import njpc_pkg::*;
#(
    parameter int W = HI_W
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         stb_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] held
);
    always_ff @(posedge clk) begin
        if (clr)         held <= '0;
        else if (!stb_n) held <= din;
    end

    AST_HI_CLEAR: assert property (@(posedge clk) clr |=> held == '0) else $error("hi clear"); // R7
    AST_HI_CAPTURE: assert property (@(posedge clk) disable iff (clr) (!stb_n) |=> held == $past(din)) else $error("hi capture"); // R4
    AST_HI_KEEP: assert property (@(posedge clk) disable iff (clr) (stb_n && !$past(clr)) |=> $stable(held)) else $error("hi keep"); // R5
endmodule

// File: rtl/njpc_counter.sv
module njpc_counter
    import njpc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int LW = NIB_W,
    localparam int HW = AW - LW
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          ld,
    input  logic [HW-1:0] hi,
    input  logic [LW-1:0] lo,
    output logic [AW-1:0] q
);
    pc_ctl_t ctl;
    pc_op_e  op;
    logic [AW-1:0] nxt;

    always_comb begin
        ctl.clr = clr;
        ctl.ld  = ld;
        op = pick_op(ctl);
        unique case (op)
            PC_CLEAR: nxt = '0;
            PC_JUMP:  nxt = {hi, lo};
            default:  nxt = q + AW'(1);
        endcase
    end

    always_ff @(posedge clk) begin
        q <= nxt;
    end

    AST_PC_CLEAR: assert property (@(posedge clk) clr |=> q == '0) else $error("pc clear"); // R1
    AST_PC_STEP: assert property (@(posedge clk) disable iff (clr) (!ld && !$past(clr)) |=> q == $past(q) + AW'(1)) else $error("pc step"); // R2
    AST_PC_JUMP: assert property (@(posedge clk) disable iff (clr) ld |=> q == {$past(hi), $past(lo)}) else $error("pc jump"); // R6
endmodule

// File: rtl/nibble_jump_pc.sv
module nibble_jump_pc
    import njpc_pkg::*;
(
    input  logic              clk,
    input  logic              hi_clr,
    input  logic              pc_clr,
    input  logic [NIB_W-1:0]  opnd,
    input  logic              hi_stb_n,
    input  logic              jump_ld,
    output logic [ADDR_W-1:0] addr
);
    logic [HI_W-1:0] hi_q;

    njpc_hi_hold #(.W(HI_W)) u_hi (
        .clk   (clk),
        .clr   (hi_clr),
        .stb_n (hi_stb_n),
        .din   (opnd[HI_W-1:0]),
        .held  (hi_q)
    );

    njpc_counter #(.AW(ADDR_W), .LW(NIB_W)) u_cnt (
        .clk (clk),
        .clr (pc_clr),
        .ld  (jump_ld),
        .hi  (hi_q),
        .lo  (opnd),
        .q   (addr)
    );

    AST_CLR_WINS: assert property (@(posedge clk) (pc_clr && jump_ld) |=> addr == '0) else $error("clear wins"); // R8
endmodule

// File: tb/sim_nibble_jump_pc.sv
module sim_nibble_jump_pc;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 0;
    logic       hi_clr = 1, pc_clr = 1, hi_stb_n = 1, jump_ld = 0;
    logic [3:0] opnd = 0;
    logic [7:0] addr;
    int n_chk = 0, n_err = 0;

    nibble_jump_pc u0 (.clk(clk), .hi_clr(hi_clr), .pc_clr(pc_clr), .opnd(opnd),
                       .hi_stb_n(hi_stb_n), .jump_ld(jump_ld), .addr(addr));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(string req, logic [7:0] exp);
        n_chk++;
        if (addr !== exp) begin
            n_err++;
            $display("FAIL %s: addr=%h expected=%h", req, addr, exp);
        end
    endtask

    task automatic idle();
        hi_clr = 0; pc_clr = 0; hi_stb_n = 1; jump_ld = 0;
    endtask

    task automatic jump(logic [3:0] lo);
        opnd = lo; jump_ld = 1; step(); idle();
    endtask

    task automatic strobe(logic [3:0] v);
        opnd = v; hi_stb_n = 0; step(); idle();
    endtask

    task automatic t_reset();
        hi_clr = 1; pc_clr = 1; step(2);
        chk("R1 reset", 8'h00);
        idle();
    endtask

    task automatic t_count();
        step(5);
        chk("R2 count", 8'h05);
    endtask

    task automatic t_jump();
        strobe(4'hA);
        chk("R2 count during strobe", 8'h06);
        jump(4'h3);
        chk("R4 R6 jump target", 8'hA3);
    endtask

    task automatic t_hold();
        opnd = 4'h7; step(3);
        chk("R2 after jump", 8'hA6);
        jump(4'h1);
        chk("R5 held nibble kept", 8'hA1);
    endtask

    task automatic t_wrap();
        strobe(4'hF);
        jump(4'hE);
        chk("R6 load FE", 8'hFE);
        step();
        chk("R2 to FF", 8'hFF);
        step();
        chk("R3 wrap", 8'h00);
    endtask

    task automatic t_hiclr();
        hi_clr = 1; step(); idle();
        chk("R7 counter runs", 8'h01);
        jump(4'h5);
        chk("R7 held cleared", 8'h05);
    endtask

    task automatic t_prio();
        strobe(4'hC);
        pc_clr = 1; jump_ld = 1; opnd = 4'h9; step(); idle();
        chk("R8 clear beats jump", 8'h00);
        jump(4'h2);
        chk("R11 held kept over pc_clr", 8'hC2);
    endtask

    task automatic t_same_edge();
        opnd = 4'h9; hi_stb_n = 0; jump_ld = 1; step(); idle();
        chk("R9 old nibble used", 8'hC9);
        jump(4'h1);
        chk("R9 R4 new nibble later", 8'h91);
        hi_clr = 1; hi_stb_n = 0; opnd = 4'h6; step(); idle();
        jump(4'h4);
        chk("R10 clear beats strobe", 8'h04);
    endtask

    initial begin
        fork
            begin
                step();
                t_reset();
                t_count();
                t_jump();
                t_hold();
                t_wrap();
                t_hiclr();
                t_prio();
                t_same_edge();
            end
            begin
                repeat (2000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule